// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects interrupt requests from six sources: one non-maskable source and five maskable ones (receiver, transmitter, line turnaround, bidirectional pin, timer). It holds each request as pending and picks the most urgent pending source. It then presents that source to the processor as a request line, a source index and a 16-bit vector address.

The high byte of every vector comes from an 8-bit base register that software can read and write. The low byte is a fixed code per source. Once a source is presented, the presentation is frozen until the processor acknowledges it. The acknowledge clears that source's pending bit and frees the controller to present the next winner.

A single global enable gates the five maskable sources. It has no effect on the non-maskable source. Reset is synchronous and active high.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `irq` is 0, `vec_addr` is 0, `src_idx` is 0 and `base_rdata` is 0. No source is pending.
- R2: When `base_wr` is high at a clock edge, `base_wdata` is stored in the base register. `base_rdata` shows the stored value from the next cycle on.
- R3: While `irq` is high, `vec_addr` equals {base, 2'b00, code}. The base is the base register value at the edge where the source was presented. The code is 28 for non-maskable, 4 for receiver, 8 for transmitter, 12 for line turnaround, 16 for bidirectional and 20 for timer.
- R4: Among pending maskable sources, the winner is chosen in this order: receiver (`src_idx` 1, `req_src[0]`), then transmitter (2, `req_src[1]`), then line turnaround (3, `req_src[2]`), then bidirectional (4, `req_src[3]`), then timer (5, `req_src[4]`).
- R5: A pending non-maskable source (`src_idx` 0) is presented ahead of any maskable source, whatever the value of `glb_en`.
- R6: The non-maskable request is edge-triggered. A 0-to-1 transition makes it pending once, and holding the input high adds no further presentations.
- R7: A maskable input that is high at a clock edge makes its source pending. The source stays pending after the input falls, until that source is acknowledged.
- R8: While `glb_en` is low, no maskable source is presented, and pending maskable sources are kept.
- R9: While `irq` is high and `ack` is low, `irq`, `vec_addr` and `src_idx` hold their values, even when a higher-priority request arrives.
- R10: When `ack` is high while `irq` is high, `irq` falls at the next edge and only the presented source's pending bit is cleared. When `ack` is high while `irq` is low, it has no effect.
- R11: When the controller is idle, a request seen at edge k is presented at edge k+1. While `irq` is low, `vec_addr` and `src_idx` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_nmi | input | 1 | Non-maskable request, edge sensitive |
| req_src | input | 5 | Maskable requests, bit 0 receiver through bit 4 timer |
| glb_en | input | 1 | Global enable for maskable sources |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | 8 | Base register write data |
| base_rdata | output | 8 | Base register read value |
| ack | input | 1 | Acknowledge of the presented source |
| irq | output | 1 | Interrupt request to the processor |
| vec_addr | output | 16 | Vector address of the presented source |
| src_idx | output | 3 | Index of the presented source |

## Verification
A lost or stuck pending bit becomes visible at the ports only when its source would win arbitration. A source that was dropped never raises `irq`. A source whose bit was not cleared is presented again one idle cycle after its acknowledge. A corrupted presentation register changes `vec_addr` or `src_idx` in the very cycle it goes wrong, so the per-cycle comparison against the bench model catches it at once. A broken edge detector on the non-maskable input shows up as repeated presentations while the input stays high.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    parameter int NUM_MASK = 5;
    parameter int BASE_W   = 8;
    localparam int NUM_SRC = NUM_MASK + 1;
    localparam int IDX_W   = $clog2(NUM_SRC + 2);
    localparam int CODE_W  = 6;
    localparam int VEC_W   = BASE_W + 2 + CODE_W;
    localparam int NMI_SLOT = 7;

    typedef enum logic [IDX_W-1:0] {
        SRC_NMI   = 3'd0,
        SRC_RX    = 3'd1,
        SRC_TX    = 3'd2,
        SRC_LTA   = 3'd3,
        SRC_BIDIR = 3'd4,
        SRC_TMR   = 3'd5
    } src_e;

    typedef struct packed {
        logic             valid;
        src_e             src;
        logic [VEC_W-1:0] vec;
    } pres_t;

    // Per-source code: slot number times four; the non-maskable source uses slot 7.
    function automatic logic [CODE_W-1:0] src_code(input src_e s);
        logic [IDX_W-1:0] slot;
        slot = (s == SRC_NMI) ? IDX_W'(NMI_SLOT) : IDX_W'(s);
        return CODE_W'({slot, 2'b00});
    endfunction

    function automatic logic [VEC_W-1:0] make_vec(input logic [BASE_W-1:0] base, input src_e s);
        return {base, 2'b00, src_code(s)};
    endfunction
endpackage

// File: rtl/irqv_edge.sv
module irqv_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise_out
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_in;
    end

    assign rise_out = level_in & ~prev_q;

    // R6: a rise lasts a single cycle however long the input stays high
    a_r6_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise_out |=> !rise_out);
endmodule

// File: rtl/irqv_pending.sv
module irqv_pending #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= (bit_q & ~clr_i[g]) | set_i[g];
        end
        assign pend_o[g] = bit_q;

        // R7: a request seen at an edge is pending afterwards
        a_r7_latch: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> pend_o[g]);
    end
endmodule

// File: rtl/irqv_select.sv
module irqv_select
    import irqv_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               glb_en,
    output logic               found_o,
    output src_e               win_o
);
    always_comb begin
        found_o = 1'b0;
        win_o   = SRC_NMI;
        for (int i = NUM_SRC - 1; i >= 1; i--) begin
            if (pend_i[i] && glb_en) begin
                found_o = 1'b1;
                win_o   = src_e'(IDX_W'(i));
            end
        end
        if (pend_i[0]) begin
            found_o = 1'b1;
            win_o   = SRC_NMI;
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_nmi,
    input  logic [NUM_MASK-1:0]   req_src,
    input  logic                  glb_en,
    input  logic                  base_wr,
    input  logic [BASE_W-1:0]     base_wdata,
    output logic [BASE_W-1:0]     base_rdata,
    input  logic                  ack,
    output logic                  irq,
    output logic [VEC_W-1:0]      vec_addr,
    output logic [IDX_W-1:0]      src_idx
);
    logic [BASE_W-1:0]  base_q;
    pres_t              pres_q;
    logic               nmi_rise;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic               found;
    src_e               win;

    irqv_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (req_nmi),
        .rise_out (nmi_rise)
    );

    assign clr = (pres_q.valid && ack) ? (NUM_SRC'(1) << pres_q.src) : '0;

    irqv_pending #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  ({req_src, nmi_rise}),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irqv_select u_sel (
        .pend_i  (pend),
        .glb_en  (glb_en),
        .found_o (found),
        .win_o   (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            pres_q <= '0;
        end else begin
            if (base_wr) base_q <= base_wdata;
            if (pres_q.valid) begin
                if (ack) pres_q <= '0;
            end else if (found) begin
                pres_q <= '{valid: 1'b1, src: win, vec: make_vec(base_q, win)};
            end
        end
    end

    assign base_rdata = base_q;
    assign irq        = pres_q.valid;
    assign vec_addr   = pres_q.vec;
    assign src_idx    = pres_q.src;

    // R1: reset leaves the outputs idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!irq && base_rdata == '0 && vec_addr == '0));

    // R9: presentation frozen until acknowledged
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> (irq && $stable(vec_addr) && $stable(src_idx)));

    // R10: acknowledge drops the request
    a_r10_ack_drop: assert property (@(posedge clk) disable iff (rst)
        (irq && ack) |=> !irq);

    // R3: the high byte is the base value seen at presentation
    a_r3_base_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (vec_addr[VEC_W-1 -: BASE_W] == $past(base_q)));

    // R5: a pending non-maskable source wins the presentation
    a_r5_nmi_first: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && $past(pend[0])) |-> (src_idx == IDX_W'(SRC_NMI)));

    // R8: a maskable source is presented only with the global enable high
    a_r8_gate: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && src_idx != IDX_W'(SRC_NMI)) |-> $past(glb_en));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_nmi = 1'b0;
    logic [4:0]  req_src = '0;
    logic        glb_en = 1'b0;
    logic        base_wr = 1'b0;
    logic [7:0]  base_wdata = '0;
    logic [7:0]  base_rdata;
    logic        ack = 1'b0;
    logic        irq;
    logic [15:0] vec_addr;
    logic [2:0]  src_idx;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst(rst), .req_nmi(req_nmi), .req_src(req_src),
        .glb_en(glb_en), .base_wr(base_wr), .base_wdata(base_wdata),
        .base_rdata(base_rdata), .ack(ack), .irq(irq),
        .vec_addr(vec_addr), .src_idx(src_idx)
    );

    // Behavioural reference model
    bit m_pend [6];
    bit m_prev;
    bit m_irq;
    int m_src;
    int m_vec;
    int m_base;

    function automatic int code_of(input int s);
        return (s == 0) ? 28 : 4 * s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            m_prev = 0; m_irq = 0; m_src = 0; m_vec = 0; m_base = 0;
        end else begin
            bit nxt [6];
            bit rise;
            rise = req_nmi && !m_prev;
            foreach (nxt[i]) nxt[i] = m_pend[i];
            if (m_irq) begin
                if (ack) begin
                    nxt[m_src] = 0;
                    m_irq = 0; m_src = 0; m_vec = 0;
                end
            end else begin
                int w;
                w = -1;
                if (m_pend[0]) w = 0;
                else if (glb_en) begin
                    for (int i = 5; i >= 1; i--) if (m_pend[i]) w = i;
                end
                if (w >= 0) begin
                    m_irq = 1; m_src = w;
                    m_vec = m_base * 256 + code_of(w);
                end
            end
            if (rise) nxt[0] = 1;
            for (int i = 1; i < 6; i++) if (req_src[i-1]) nxt[i] = 1;
            foreach (m_pend[i]) m_pend[i] = nxt[i];
            m_prev = req_nmi;
            if (base_wr) m_base = base_wdata;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R11 irq vs model", int'(irq), int'(m_irq));
            chk("R4 src_idx vs model", int'(src_idx), m_src);
            chk("R3 vec_addr vs model", int'(vec_addr), m_vec);
            chk("R2 base_rdata vs model", int'(base_rdata), m_base);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(tag, int'(irq), 1);
    endtask

    task automatic do_ack();
        ack = 1'b1; cyc(1); ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 irq", int'(irq), 0);
        chk("R1 vec", int'(vec_addr), 0);
        chk("R1 idx", int'(src_idx), 0);
        chk("R1 base", int'(base_rdata), 0);

        base_wr = 1'b1; base_wdata = 8'hA5; cyc(1); base_wr = 1'b0;
        chk("R2 base write", int'(base_rdata), 'hA5);

        glb_en = 1'b1;
        req_src = 5'b00001; cyc(1); req_src = '0;
        wait_irq("R7 pulse stays pending");
        chk("R4 rx idx", int'(src_idx), 1);
        chk("R3 rx vec", int'(vec_addr), 'hA504);

        req_nmi = 1'b1; cyc(3);
        chk("R9 idx held", int'(src_idx), 1);
        chk("R9 vec held", int'(vec_addr), 'hA504);
        do_ack();
        chk("R10 irq drops", int'(irq), 0);
        wait_irq("R5 nmi presented");
        chk("R5 nmi idx", int'(src_idx), 0);
        chk("R3 nmi vec", int'(vec_addr), 'hA51C);
        do_ack();
        cyc(5);
        chk("R6 held nmi no repeat", int'(irq), 0);
        req_nmi = 1'b0; cyc(1);

        glb_en = 1'b0;
        req_src = 5'b11111; cyc(1); req_src = '0;
        cyc(4);
        chk("R8 gated", int'(irq), 0);
        glb_en = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            wait_irq("R8 pending kept");
            chk("R4 order", int'(src_idx), k);
            chk("R3 code", int'(vec_addr), 'hA500 + 4 * k);
            do_ack();
        end
        cyc(4);
        chk("R10 all cleared", int'(irq), 0);

        glb_en = 1'b0;
        req_nmi = 1'b1; cyc(1);
        wait_irq("R5 nmi ignores enable");
        chk("R5 idx", int'(src_idx), 0);
        do_ack();
        req_nmi = 1'b0;

        req_src = 5'b10000; cyc(1); req_src = '0;
        ack = 1'b1; cyc(2); ack = 1'b0;
        base_wr = 1'b1; base_wdata = 8'h3C; cyc(1); base_wr = 1'b0;
        glb_en = 1'b1;
        wait_irq("R10 idle ack ignored");
        chk("R10 timer idx", int'(src_idx), 5);
        chk("R3 new base", int'(vec_addr), 'h3C14);
        do_ack();
        cyc(2);

        for (int t = 0; t < 3000; t++) begin
            for (int b = 0; b < 5; b++) req_src[b] = ($urandom % 8) == 0;
            if (($urandom % 10) == 0) req_nmi = ~req_nmi;
            if (($urandom % 20) == 0) glb_en = ~glb_en;
            ack = ($urandom % 3) == 0;
            base_wr = ($urandom % 16) == 0;
            base_wdata = 8'($urandom);
            cyc(1);
        end
        req_src = '0; ack = 1'b0; base_wr = 1'b0;
        cyc(2);
        finish_run();
    end
endmodule